// File: doc/BRIEF.md
# Microcode sequencer with hardwired decode fallback

This block sits in the decode stage and turns a stream of instruction opcodes into a stream of micro-operations. Most opcodes are decoded by a hardwired expander. The expander produces one to four micro-ops, one per cycle, and does not touch the control store. The rest of the opcode space is reserved for complex instructions. For these, the hardwired path stops taking opcodes while a sequencer walks a routine held in a small constant control store. It injects the routine's words in order and then hands control back to the hardwired path.

The low opcode bits pick the routine, and a fixed dispatch table maps them to a start address. Each control-store word carries an action code, a branch condition, a branch target and an end-of-routine bit. A branch condition can step to the next word, jump unconditionally, jump on the external condition flag or on its inverse, or loop on a private iteration counter. The iteration counter is loaded at routine entry. It lets a multiply routine run one shift-and-conditional-add pass per multiplier bit. Both handshakes are valid/ready. A stalled micro-op stays on the output unchanged.

Top module: `useq_top`

## Requirements
- R1: A synchronous reset, applied in any state, leaves `uop_valid_o` low and `opc_ready_o` high in the first cycle after it is released. Decoding then proceeds normally.
- R2: An opcode whose two most significant bits are both 1 is complex and is handled by the sequencer. Every other opcode is simple and is handled by the hardwired expander. Bit 7 of the micro-op (its most significant bit) is 0 for hardwired micro-ops and 1 for micro-ops taken from the control store.
- R3: A simple opcode `p` produces `p[1:0]+1` micro-ops. Micro-op number `i`, counting from 0, has the format {0, p, i[1:0], last}, where `last` is 1 only on the final micro-op.
- R4: The first micro-op of an accepted opcode is valid in the cycle after acceptance. While the output is ready, the next opcode is accepted in the cycle in which the previous simple opcode's last micro-op is taken, so simple micro-ops flow without a gap.
- R5: A complex opcode starts its routine at control-store address 0, 5, 8 or 11 for low bits 0, 1, 2 or 3. A sequencer micro-op has the format {1, zero padding, action[3:0], end}. Low bits 1 give actions 6, 7, 8, with the end bit set on 8.
- R6: The sequencer emits routine words one at a time, in order. After the word with the end bit set is taken, `opc_ready_o` is high in the next cycle.
- R7: `opc_ready_o` stays low from the cycle after a complex opcode is accepted until its last routine word has been taken.
- R8: The compare routine (low bits 2) emits action 9 and samples `flag_i` in the cycle that micro-op is taken. If the flag is 1 it next emits action 11 (end). If the flag is 0 it next emits action 10 (end).
- R9: The multiply routine (low bits 0) emits action 1 first. It then runs exactly MUL_BITS passes. Each pass emits action 2 (test), then action 3 (add) only if `flag_i` was 1 when the test was taken, then action 4 (shift). The routine finishes with action 5 (end).
- R10: The routine for low bits 3 emits action 12, jumps unconditionally past the word that follows it, and then emits action 11 (end).
- R11: While `uop_valid_o` is high and `uop_ready_i` is low, the next cycle keeps `uop_valid_o` high and `uop_o` unchanged. No micro-op is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| opc_valid_i | input | 1 | Opcode offered |
| opc_ready_o | output | 1 | Opcode taken when valid and ready are both high |
| opc_i | input | OPC_W | Instruction opcode |
| flag_i | input | 1 | Condition flag sampled by conditional micro-branches |
| uop_valid_o | output | 1 | Micro-op present |
| uop_ready_i | input | 1 | Downstream accepts the micro-op |
| uop_o | output | OPC_W+4 | Micro-op word |

## Verification
The assertions assume that `flag_i` is meaningful only in a cycle where a conditional micro-op is being taken, and that the downstream stage may stall without limit. They also assume that `opc_i` may change freely while `opc_valid_i` is low. The stimulus drives all inputs on the falling edge. It derives the flag from the multiplier value bit indexed by the number of test micro-ops already taken, so every flag value the bench applies is one it expects. Three ready patterns (always high, low every third cycle, low every other cycle) run every routine under stall without ever holding ready low forever.

// File: rtl/useq_pkg.sv
package useq_pkg;

   localparam int ACT_W  = 4;
   localparam int COND_W = 3;

   typedef enum logic [COND_W-1:0] {
      C_SEQ  = 3'd0,
      C_JMP  = 3'd1,
      C_JF   = 3'd2,
      C_JNF  = 3'd3,
      C_LOOP = 3'd4
   } cond_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HW   = 2'd1,
      ST_UC   = 2'd2
   } st_e;

   localparam logic [ACT_W-1:0] A_MINIT = 4'd1;
   localparam logic [ACT_W-1:0] A_TEST  = 4'd2;
   localparam logic [ACT_W-1:0] A_ADD   = 4'd3;
   localparam logic [ACT_W-1:0] A_SHIFT = 4'd4;
   localparam logic [ACT_W-1:0] A_WB    = 4'd5;
   localparam logic [ACT_W-1:0] A_LOAD  = 4'd6;
   localparam logic [ACT_W-1:0] A_ALU   = 4'd7;
   localparam logic [ACT_W-1:0] A_STORE = 4'd8;
   localparam logic [ACT_W-1:0] A_CMP   = 4'd9;
   localparam logic [ACT_W-1:0] A_FIX   = 4'd10;
   localparam logic [ACT_W-1:0] A_DONE  = 4'd11;
   localparam logic [ACT_W-1:0] A_JMP   = 4'd12;
   localparam logic [ACT_W-1:0] A_TRAP  = 4'd15;

   localparam int E_MUL = 0;
   localparam int E_MOV = 5;
   localparam int E_CMP = 8;
   localparam int E_JMP = 11;

   localparam int CS_MIN_AW = 4;

endpackage

// File: rtl/useq_hw_expand.sv
module useq_hw_expand #(
   parameter int OPC_W = 4,
   parameter int UOP_W = OPC_W + 4
) (
   input  logic [OPC_W-1:0] opc_i,
   output logic             is_complex_o,
   output logic [1:0]       rt_sel_o,
   input  logic [OPC_W-1:0] cur_opc_i,
   input  logic [1:0]       idx_i,
   output logic             last_o,
   output logic [UOP_W-1:0] uop_o
);

   // complex class: both top opcode bits set
   assign is_complex_o = &opc_i[OPC_W-1 -: 2];
   assign rt_sel_o     = opc_i[1:0];

   // expansion length is carried in the two low opcode bits
   assign last_o = (idx_i == cur_opc_i[1:0]);
   assign uop_o  = {1'b0, cur_opc_i, idx_i, last_o};

endmodule

// File: rtl/useq_ctrl_store.sv
module useq_ctrl_store
   import useq_pkg::*;
#(
   parameter int CS_AW = 4
) (
   input  logic [CS_AW-1:0] addr_i,
   input  logic [1:0]       rt_sel_i,
   output logic [ACT_W-1:0] act_o,
   output cond_e            cond_o,
   output logic [CS_AW-1:0] nxt_o,
   output logic             fin_o,
   output logic [CS_AW-1:0] entry_o
);

   localparam int DEPTH  = 1 << CS_AW;
   localparam int WORD_W = ACT_W + COND_W + CS_AW + 1;

   function automatic logic [WORD_W-1:0] mk(logic [ACT_W-1:0] a, cond_e c, int n, logic f);
      return {a, c, CS_AW'(n), f};
   endfunction

   function automatic logic [WORD_W-1:0] cs_word(int a);
      case (a)
         0:       return mk(A_MINIT, C_SEQ,  0, 1'b0);
         1:       return mk(A_TEST,  C_JNF,  3, 1'b0);
         2:       return mk(A_ADD,   C_SEQ,  0, 1'b0);
         3:       return mk(A_SHIFT, C_LOOP, 1, 1'b0);
         4:       return mk(A_WB,    C_SEQ,  0, 1'b1);
         5:       return mk(A_LOAD,  C_SEQ,  0, 1'b0);
         6:       return mk(A_ALU,   C_SEQ,  0, 1'b0);
         7:       return mk(A_STORE, C_SEQ,  0, 1'b1);
         8:       return mk(A_CMP,   C_JF,  10, 1'b0);
         9:       return mk(A_FIX,   C_SEQ,  0, 1'b1);
         10:      return mk(A_DONE,  C_SEQ,  0, 1'b1);
         11:      return mk(A_JMP,   C_JMP, 13, 1'b0);
         12:      return mk(A_TRAP,  C_SEQ,  0, 1'b1);
         13:      return mk(A_DONE,  C_SEQ,  0, 1'b1);
         default: return mk(A_TRAP,  C_SEQ,  0, 1'b1);
      endcase
   endfunction

   logic [WORD_W-1:0] rom [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_rom
         assign rom[g] = cs_word(g);
      end
   endgenerate

   logic [WORD_W-1:0] word;
   logic [COND_W-1:0] cond_bits;

   assign word = rom[addr_i];
   assign {act_o, cond_bits, nxt_o, fin_o} = word;
   assign cond_o = cond_e'(cond_bits);

   always_comb begin
      case (rt_sel_i)
         2'd0:    entry_o = CS_AW'(E_MUL);
         2'd1:    entry_o = CS_AW'(E_MOV);
         2'd2:    entry_o = CS_AW'(E_CMP);
         default: entry_o = CS_AW'(E_JMP);
      endcase
   end

endmodule

// File: rtl/useq_branch.sv
module useq_branch
   import useq_pkg::*;
#(
   parameter int CS_AW = 4,
   parameter int CNT_W = 2
) (
   input  cond_e            cond_i,
   input  logic [CS_AW-1:0] upc_i,
   input  logic [CS_AW-1:0] nxt_i,
   input  logic             flag_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [CS_AW-1:0] upc_o,
   output logic [CNT_W-1:0] cnt_o
);

   logic [CS_AW-1:0] seq;
   assign seq = upc_i + 1'b1;

   always_comb begin
      upc_o = seq;
      cnt_o = cnt_i;
      case (cond_i)
         C_JMP:  upc_o = nxt_i;
         C_JF:   upc_o = flag_i ? nxt_i : seq;
         C_JNF:  upc_o = flag_i ? seq : nxt_i;
         C_LOOP: begin
            if (cnt_i != '0) begin
               upc_o = nxt_i;
               cnt_o = cnt_i - 1'b1;
            end
         end
         default: upc_o = seq;
      endcase
   end

endmodule

// File: rtl/useq_top.sv
module useq_top
   import useq_pkg::*;
#(
   parameter int OPC_W    = 4,
   parameter int CS_AW    = 4,
   parameter int MUL_BITS = 4
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             opc_valid_i,
   output logic             opc_ready_o,
   input  logic [OPC_W-1:0] opc_i,
   input  logic             flag_i,
   output logic             uop_valid_o,
   input  logic             uop_ready_i,
   output logic [OPC_W+3:0] uop_o
);

   localparam int UOP_W = OPC_W + 4;
   localparam int CNT_W = $clog2(MUL_BITS);
   localparam int PAD_W = OPC_W - 2;

   generate
      if (OPC_W < 3) begin : g_bad_opc
         $error("useq_top: OPC_W must be at least 3");
      end
      if (CS_AW < CS_MIN_AW) begin : g_bad_cs
         $error("useq_top: control store too small for routines");
      end
      if (MUL_BITS < 2) begin : g_bad_mul
         $error("useq_top: MUL_BITS must be at least 2");
      end
   endgenerate

   st_e              state_q, state_d;
   logic [OPC_W-1:0] opc_q,   opc_d;
   logic [1:0]       idx_q,   idx_d;
   logic [CS_AW-1:0] upc_q,   upc_d;
   logic [CNT_W-1:0] cnt_q,   cnt_d;

   logic             is_cplx;
   logic [1:0]       rt_sel;
   logic             hw_last;
   logic [UOP_W-1:0] hw_uop;

   logic [ACT_W-1:0] cs_act;
   cond_e            cs_cond;
   logic [CS_AW-1:0] cs_nxt;
   logic             cs_fin;
   logic [CS_AW-1:0] cs_entry;

   logic [CS_AW-1:0] br_upc;
   logic [CNT_W-1:0] br_cnt;

   logic             fire;
   logic             accept;

   useq_hw_expand #(.OPC_W(OPC_W), .UOP_W(UOP_W)) u_hw (
      .opc_i        (opc_i),
      .is_complex_o (is_cplx),
      .rt_sel_o     (rt_sel),
      .cur_opc_i    (opc_q),
      .idx_i        (idx_q),
      .last_o       (hw_last),
      .uop_o        (hw_uop)
   );

   useq_ctrl_store #(.CS_AW(CS_AW)) u_cs (
      .addr_i   (upc_q),
      .rt_sel_i (rt_sel),
      .act_o    (cs_act),
      .cond_o   (cs_cond),
      .nxt_o    (cs_nxt),
      .fin_o    (cs_fin),
      .entry_o  (cs_entry)
   );

   useq_branch #(.CS_AW(CS_AW), .CNT_W(CNT_W)) u_br (
      .cond_i (cs_cond),
      .upc_i  (upc_q),
      .nxt_i  (cs_nxt),
      .flag_i (flag_i),
      .cnt_i  (cnt_q),
      .upc_o  (br_upc),
      .cnt_o  (br_cnt)
   );

   assign uop_valid_o = (state_q != ST_IDLE);
   assign fire        = uop_valid_o && uop_ready_i;
   assign opc_ready_o = (state_q == ST_IDLE) ||
                        ((state_q == ST_HW) && hw_last && uop_ready_i);
   assign accept      = opc_valid_i && opc_ready_o;

   assign uop_o = (state_q == ST_UC) ? {1'b1, {PAD_W{1'b0}}, cs_act, cs_fin} : hw_uop;

   always_comb begin
      state_d = state_q;
      opc_d   = opc_q;
      idx_d   = idx_q;
      upc_d   = upc_q;
      cnt_d   = cnt_q;
      case (state_q)
         ST_HW: begin
            if (fire) begin
               if (hw_last) state_d = ST_IDLE;
               else         idx_d   = idx_q + 1'b1;
            end
         end
         ST_UC: begin
            if (fire) begin
               if (cs_fin) begin
                  state_d = ST_IDLE;
               end else begin
                  upc_d = br_upc;
                  cnt_d = br_cnt;
               end
            end
         end
         default: ;
      endcase
      if (accept) begin
         if (is_cplx) begin
            state_d = ST_UC;
            upc_d   = cs_entry;
            cnt_d   = CNT_W'(MUL_BITS - 1);
         end else begin
            state_d = ST_HW;
            opc_d   = opc_i;
            idx_d   = '0;
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= ST_IDLE;
         opc_q   <= '0;
         idx_q   <= '0;
         upc_q   <= '0;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         opc_q   <= opc_d;
         idx_q   <= idx_d;
         upc_q   <= upc_d;
         cnt_q   <= cnt_d;
      end
   end

endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
   parameter int OPC_W = 4
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             opc_valid_i,
   input logic             opc_ready_o,
   input logic [OPC_W-1:0] opc_i,
   input logic             uop_valid_o,
   input logic             uop_ready_i,
   input logic [OPC_W+3:0] uop_o
);

   localparam int UW = OPC_W + 4;

   logic acc;
   logic fire;
   assign acc  = opc_valid_i && opc_ready_o;
   assign fire = uop_valid_o && uop_ready_i;

   // R1
   a_r1_reset_idle: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rst_i) |-> (!uop_valid_o && opc_ready_o));

   // R4
   a_r4_first_uop: assert property (@(posedge clk_i) disable iff (rst_i)
      acc |=> uop_valid_o);

   // R2
   a_r2_complex_path: assert property (@(posedge clk_i) disable iff (rst_i)
      (acc && (&opc_i[OPC_W-1 -: 2])) |=> uop_o[UW-1]);

   // R2, R3
   a_r2_simple_path: assert property (@(posedge clk_i) disable iff (rst_i)
      (acc && !(&opc_i[OPC_W-1 -: 2])) |=>
         (!uop_o[UW-1] && (uop_o[UW-2 -: OPC_W] == $past(opc_i)) && (uop_o[2:1] == 2'd0)));

   // R3
   a_r3_step_order: assert property (@(posedge clk_i) disable iff (rst_i)
      (fire && !uop_o[UW-1] && !uop_o[0]) |=>
         (uop_valid_o && !uop_o[UW-1] && $stable(uop_o[UW-2 -: OPC_W]) &&
          (uop_o[2:1] == 2'($past(uop_o[2:1]) + 2'd1))));

   // R7
   a_r7_busy: assert property (@(posedge clk_i) disable iff (rst_i)
      (uop_valid_o && uop_o[UW-1]) |-> !opc_ready_o);

   // R6
   a_r6_resume: assert property (@(posedge clk_i) disable iff (rst_i)
      (fire && uop_o[UW-1] && uop_o[0]) |=> (opc_ready_o && !uop_valid_o));

   // R11
   a_r11_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      (uop_valid_o && !uop_ready_i) |=> (uop_valid_o && $stable(uop_o)));

endmodule

bind useq_top useq_chk #(.OPC_W(OPC_W)) u_chk (
   .clk_i       (clk_i),
   .rst_i       (rst_i),
   .opc_valid_i (opc_valid_i),
   .opc_ready_o (opc_ready_o),
   .opc_i       (opc_i),
   .uop_valid_o (uop_valid_o),
   .uop_ready_i (uop_ready_i),
   .uop_o       (uop_o)
);

// File: tb/useq_top_tb_top.sv
module useq_top_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int OW = 4;
   localparam int UW = 8;
   localparam int MB = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          opc_valid = 1'b0;
   logic          opc_ready;
   logic [OW-1:0] opc = '0;
   logic          flag = 1'b0;
   logic          uop_valid;
   logic          uop_ready = 1'b0;
   logic [UW-1:0] uop;

   always #2.5 clk = ~clk;

   useq_top #(.OPC_W(OW), .CS_AW(4), .MUL_BITS(MB)) dut_i (
      .clk_i       (clk),
      .rst_i       (rst),
      .opc_valid_i (opc_valid),
      .opc_ready_o (opc_ready),
      .opc_i       (opc),
      .flag_i      (flag),
      .uop_valid_o (uop_valid),
      .uop_ready_i (uop_ready),
      .uop_o       (uop)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [OW-1:0] opq [16];
   int            nq = 0;
   int            qp = 0;
   logic [UW-1:0] got [64];
   int            got_cyc [64];
   int            ngot = 0;
   int            acc_cyc [16];
   int            nacc = 0;
   logic [UW-1:0] expv [64];
   int            nexp = 0;
   int            exp_tests = 0;
   logic [15:0]   mval = '0;
   int            test_seen = 0;
   int            cyc = 0;
   int            mode = 0;
   bit            in_rt = 1'b0;
   int            rt_viol = 0;
   bit            stalled = 1'b0;
   logic [UW-1:0] held = '0;
   int            hold_bad = 0;

   task automatic chk(bit ok, string req, string what, int act, int expd);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expd);
      end
   endtask

   function automatic logic [UW-1:0] ucw(int a, bit f);
      return {1'b1, 2'b00, 4'(a), f};
   endfunction

   task automatic exp_push(logic [UW-1:0] w);
      if (nexp < 64) begin
         expv[nexp] = w;
         nexp++;
      end
   endtask

   task automatic exp_add(logic [OW-1:0] op);
      if (op[3:2] != 2'b11) begin
         for (int i = 0; i <= int'(op[1:0]); i++)
            exp_push({1'b0, op, 2'(i), (i == int'(op[1:0]))});
      end else begin
         case (op[1:0])
            2'd0: begin
               exp_push(ucw(1, 1'b0));
               for (int k = 0; k < MB; k++) begin
                  exp_push(ucw(2, 1'b0));
                  if (mval[exp_tests]) exp_push(ucw(3, 1'b0));
                  exp_tests++;
                  exp_push(ucw(4, 1'b0));
               end
               exp_push(ucw(5, 1'b1));
            end
            2'd1: begin
               exp_push(ucw(6, 1'b0));
               exp_push(ucw(7, 1'b0));
               exp_push(ucw(8, 1'b1));
            end
            2'd2: begin
               exp_push(ucw(9, 1'b0));
               if (mval[exp_tests]) exp_push(ucw(11, 1'b1));
               else                 exp_push(ucw(10, 1'b1));
            end
            default: begin
               exp_push(ucw(12, 1'b0));
               exp_push(ucw(11, 1'b1));
            end
         endcase
      end
   endtask

   task automatic tick();
      @(negedge clk);
      cyc++;
      case (mode)
         0:       uop_ready = 1'b1;
         1:       uop_ready = (cyc % 3) != 0;
         default: uop_ready = (cyc % 2) == 0;
      endcase
      flag      = mval[test_seen[3:0]];
      opc_valid = (qp < nq);
      opc       = (qp < nq) ? opq[qp] : '0;
      #1;
      if (stalled && !(uop_valid && uop == held)) hold_bad++;
      stalled = uop_valid && !uop_ready;
      held    = uop;
      if (in_rt && opc_ready) rt_viol++;
      if (uop_valid && uop_ready) begin
         if (ngot < 64) begin
            got[ngot]     = uop;
            got_cyc[ngot] = cyc;
            ngot++;
         end
         if (uop[7] && uop[4:1] == 4'd2 && test_seen < 15) test_seen++;
         if (uop[7] && uop[0]) in_rt = 1'b0;
      end
      if (opc_valid && opc_ready) begin
         if (nacc < 16) begin
            acc_cyc[nacc] = cyc;
            nacc++;
         end
         if (opc[3:2] == 2'b11) in_rt = 1'b1;
         qp++;
      end
   endtask

   task automatic run(int m, string req);
      int bad;
      mode = m; qp = 0; ngot = 0; nacc = 0; test_seen = 0;
      in_rt = 1'b0; rt_viol = 0; stalled = 1'b0; hold_bad = 0;
      nexp = 0; exp_tests = 0;
      for (int i = 0; i < nq; i++) exp_add(opq[i]);
      for (int t = 0; t < 600; t++) begin
         tick();
         if (qp == nq && !uop_valid && nacc > 0 && cyc > acc_cyc[nacc-1]) break;
      end
      chk(ngot == nexp, req, "micro-op count", ngot, nexp);
      bad = -1;
      for (int i = 0; i < ngot && i < nexp; i++)
         if (bad < 0 && got[i] != expv[i]) bad = i;
      if (bad < 0) chk(1'b1, req, "micro-op stream", 0, 0);
      else chk(1'b0, req, "micro-op word", int'(got[bad]), int'(expv[bad]));
      chk(rt_viol == 0, "R7", "opcode-ready cycles during routine", rt_viol, 0);
      if (m != 0) chk(hold_bad == 0, "R11", "changed outputs under stall", hold_bad, 0);
   endtask

   initial begin
      #(200000 * 5.0);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      chk(!uop_valid && opc_ready, "R1", "valid/ready after reset",
          {uop_valid, opc_ready}, 1);

      // R3 R4: all simple opcodes, back to back
      nq = 12;
      for (int i = 0; i < 12; i++) opq[i] = 4'(i);
      run(0, "R3");
      chk(got_cyc[0] == acc_cyc[0] + 1, "R4", "first micro-op cycle",
          got_cyc[0] - acc_cyc[0], 1);
      chk(acc_cyc[1] == got_cyc[0], "R4", "next opcode accept cycle",
          acc_cyc[1] - got_cyc[0], 0);
      chk(got_cyc[ngot-1] - got_cyc[0] == ngot - 1, "R4", "span of simple stream",
          got_cyc[ngot-1] - got_cyc[0], ngot - 1);
      run(1, "R3");
      run(2, "R11");

      // R9: every multiplier value, rotating ready patterns
      nq = 1;
      opq[0] = 4'd12;
      for (int v = 0; v < 16; v++) begin
         mval = 16'(v);
         run(v % 3, "R9");
      end

      // R5 R6: linear routine followed by a simple opcode
      mval = '0;
      nq = 2;
      opq[0] = 4'd13;
      opq[1] = 4'd5;
      run(0, "R5");
      chk(acc_cyc[1] == got_cyc[2] + 1, "R6", "resume accept cycle",
          acc_cyc[1] - got_cyc[2], 1);
      run(1, "R6");

      // R8: compare routine on both flag values
      nq = 1;
      opq[0] = 4'd14;
      mval = 16'h0000; run(0, "R8");
      mval = 16'h0001; run(0, "R8");
      mval = 16'h0000; run(2, "R8");
      mval = 16'h0001; run(1, "R8");

      // R10: unconditional jump routine
      opq[0] = 4'd15;
      run(0, "R10");
      run(1, "R10");

      // R2: mixed classes in one stream
      nq = 6;
      opq[0] = 4'd11; opq[1] = 4'd12; opq[2] = 4'd14;
      opq[3] = 4'd15; opq[4] = 4'd3;  opq[5] = 4'd13;
      mval = 16'hA5C3;
      run(2, "R2");

      // R1: reset in the middle of a routine
      mval = 16'h0005;
      mode = 0; nq = 1; opq[0] = 4'd12; qp = 0; test_seen = 0;
      in_rt = 1'b0; stalled = 1'b0;
      repeat (4) tick();
      @(negedge clk);
      rst = 1'b1;
      opc_valid = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk(!uop_valid && opc_ready, "R1", "valid/ready after mid-routine reset",
          {uop_valid, opc_ready}, 1);
      nq = 1;
      opq[0] = 4'd6;
      run(0, "R1");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule